// File: doc/BRIEF.md
# Accumulator XOR Execution Unit

This unit carries out the 8-bit exclusive-OR group of a small accumulator CPU. It receives one opcode together with the byte that follows it in the stream. From the opcode it picks an operand: one of the general registers, the accumulator itself, a byte read from memory at the H:L address, or the following byte. It XORs that operand into the accumulator. It then hands the new accumulator value and a new flag byte to the surrounding register file as single-cycle write strobes. Together with the write strobes it reports the instruction length in bytes and its cycle cost.

The register file sits outside the unit. The unit reads the registers through ports at the moment it accepts an opcode, and it returns writes through strobes. An opcode is accepted in any cycle where `op_valid` and `ready` are both high. The register and immediate forms complete one cycle after acceptance. The memory form raises a read request and holds it until the memory answers. The unit completes the instruction in the cycle after it sees the answer. An opcode outside the group completes with an error pulse and writes nothing.

Top module: `xor_exec_unit`

## Requirements
- R1: Opcodes 0xA8, 0xA9, 0xAA, 0xAB, 0xAC and 0xAD take their operand from `b_in`, `c_in`, `d_in`, `e_in`, `h_in` and `l_in` respectively. On completion, `acc_wr_data` equals `acc_in` XOR that operand.
- R2: Opcode 0xAF uses the accumulator as its own operand, so the written value is 0x00 and the zero flag is set.
- R3: Opcode 0xAE raises `mem_req` in the cycle after acceptance, with `mem_addr` = {`h_in`,`l_in`} as they were at acceptance. Both stay constant until `mem_rvalid` is sampled high. The result `acc_in` XOR `mem_rdata` is committed in the following cycle.
- R4: Opcode 0xEE takes its operand from `imm_in` as it was at acceptance.
- R5: `flag_wr_data` bit 7 (zero) is 1 exactly when the written accumulator value is 0. Bits 6 (subtract), 5 (half-carry) and 4 (carry) and the low nibble are always written as 0.
- R6: On completion, `instr_len` is 2 for 0xEE and 1 for every other opcode in the group.
- R7: On completion, `instr_cycles` is 4 for the register forms (0xA8–0xAD, 0xAF) and 8 for 0xAE and 0xEE.
- R8: Any other opcode completes with `done` and `unknown_op` high, `acc_wr_en` and `flag_wr_en` low, and `instr_len` and `instr_cycles` both 0.
- R9: For every non-memory opcode, `done` is a one-cycle pulse in the cycle right after acceptance. `acc_wr_en` and `flag_wr_en` pulse together with it for known opcodes.
- R10: `ready` is low while a memory read is pending and during the `done` cycle. An `op_valid` seen while `ready` is low is ignored and produces no completion.
- R11: After a synchronous active-low reset, `ready` is 1 and `done`, `mem_req`, `acc_wr_en`, `flag_wr_en` and `unknown_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Opcode offered this cycle |
| opcode | input | 8 | Opcode byte |
| imm_in | input | 8 | Byte following the opcode |
| ready | output | 1 | Unit can accept an opcode this cycle |
| acc_in | input | 8 | Accumulator value |
| b_in | input | 8 | Register B value |
| c_in | input | 8 | Register C value |
| d_in | input | 8 | Register D value |
| e_in | input | 8 | Register E value |
| h_in | input | 8 | Register H value (address high byte) |
| l_in | input | 8 | Register L value (address low byte) |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 8 | Memory read data |
| done | output | 1 | Instruction completion pulse |
| acc_wr_en | output | 1 | Accumulator write strobe |
| acc_wr_data | output | 8 | New accumulator value |
| flag_wr_en | output | 1 | Flag register write strobe |
| flag_wr_data | output | 8 | New flag byte |
| unknown_op | output | 1 | Opcode not in the group |
| instr_len | output | 2 | Instruction length in bytes, valid with done |
| instr_cycles | output | 4 | Cycle cost, valid with done |

## Verification
The assertions assume that the memory answers only while `mem_req` is high, and that the register inputs hold steady in the cycle an opcode is accepted. They also assume `mem_rvalid` is a single-cycle pulse. The bench drives `mem_rvalid` for one cycle only, and only after it has seen `mem_req`. It changes register values and `imm_in` only on the falling edge before it offers an opcode. It offers a second opcode during a pending read and during the completion cycle, to show that the unit drops it.

// File: rtl/xor_unit_pkg.sv
// Package: shared constants and types of the XOR execution unit.
// Assumes an 8-bit datapath. Opcode values are fixed by the instruction set.
package xor_unit_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned LEN_W  = 2;
    localparam int unsigned CYC_W  = 4;

    // Opcode group: 10101xxx selects a register slot, 0xEE is the immediate form
    localparam logic [4:0]        REG_GROUP_HI = 5'b10101;
    localparam logic [DATA_W-1:0] IMM_OPCODE   = 8'hEE;

    // Slot numbers inside the 10101xxx group
    localparam logic [2:0] SLOT_MEM = 3'd6;
    localparam logic [2:0] SLOT_ACC = 3'd7;

    // Flag byte bit positions
    localparam int unsigned FLAG_Z = 7;
    localparam int unsigned FLAG_N = 6;
    localparam int unsigned FLAG_H = 5;
    localparam int unsigned FLAG_C = 4;

    typedef enum logic [1:0] {
        FORM_REG  = 2'd0,
        FORM_MEM  = 2'd1,
        FORM_IMM  = 2'd2,
        FORM_NONE = 2'd3
    } form_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_MEM_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/xor_decode.sv
// xor_decode: combinational decode of one opcode into an operand form,
// an operand slot, the length in bytes and the cycle cost.
// Assumes: opcode is stable while it is decoded; the slot only matters for
// FORM_REG and FORM_IMM (the immediate uses slot SLOT_MEM of the bank).
module xor_decode
    import xor_unit_pkg::*;
#(
    parameter int unsigned SHORT_CYCLES = 4,
    parameter int unsigned LONG_CYCLES  = 8
) (
    input  logic [DATA_W-1:0] opcode,
    output form_e             form,
    output logic [2:0]        slot,
    output logic [LEN_W-1:0]  len,
    output logic [CYC_W-1:0]  cycles
);

    localparam logic [CYC_W-1:0] SHORT_C = CYC_W'(SHORT_CYCLES);
    localparam logic [CYC_W-1:0] LONG_C  = CYC_W'(LONG_CYCLES);

    // Purpose: classify the opcode and look up its length and cost
    always_comb begin
        form   = FORM_NONE;
        slot   = SLOT_MEM;
        len    = '0;
        cycles = '0;
        if (opcode[7:3] == REG_GROUP_HI) begin
            slot = opcode[2:0];
            len  = LEN_W'(1);
            if (opcode[2:0] == SLOT_MEM) begin
                form   = FORM_MEM;
                cycles = LONG_C;
            end else begin
                form   = FORM_REG;
                cycles = SHORT_C;
            end
        end else if (opcode == IMM_OPCODE) begin
            form   = FORM_IMM;
            slot   = SLOT_MEM;
            len    = LEN_W'(2);
            cycles = LONG_C;
        end
    end

endmodule

// File: rtl/xor_operand_mux.sv
// xor_operand_mux: picks the operand byte from an eight-entry bank.
// Entries 0..5 are B..L, entry 6 carries the immediate byte, entry 7 is the
// accumulator. Assumes the slot comes from xor_decode.
module xor_operand_mux
    import xor_unit_pkg::*;
#(
    parameter int unsigned SLOTS = 8
) (
    input  logic [SLOTS-1:0][DATA_W-1:0] bank,
    input  logic [$clog2(SLOTS)-1:0]     slot,
    output logic [DATA_W-1:0]            operand
);

    // Purpose: AND-OR select so the mux stays one level of gates per bit
    always_comb begin
        operand = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot == ($clog2(SLOTS))'(i)) begin
                operand = operand | bank[i];
            end
        end
    end

endmodule

// File: rtl/xor_alu.sv
// xor_alu: XORs the operand into the accumulator and forms the flag byte.
// Only the zero flag depends on the data; the other three and the low
// nibble are always zero. Purely combinational.
module xor_alu
    import xor_unit_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags
);

    // Purpose: compute the result and the flag byte
    always_comb begin
        result         = acc ^ operand;
        flags          = '0;
        flags[FLAG_Z]  = (result == '0);
        flags[FLAG_N]  = 1'b0;
        flags[FLAG_H]  = 1'b0;
        flags[FLAG_C]  = 1'b0;
    end

endmodule

// File: rtl/xor_seq.sv
// xor_seq: acceptance, memory wait and commit sequencing.
// Assumes: mem_rvalid only while mem_req is high; the ALU inputs are
// selected by the parent from state (live inputs when idle, latched
// accumulator and memory data while waiting). All outputs are registered.
module xor_seq
    import xor_unit_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  form_e             form,
    input  logic [LEN_W-1:0]  len,
    input  logic [CYC_W-1:0]  cycles,
    input  logic [ADDR_W-1:0] hl_addr,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [DATA_W-1:0] alu_flags,
    input  logic              mem_rvalid,
    output logic              ready,
    output logic              waiting,
    output logic [DATA_W-1:0] acc_hold,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              done,
    output logic              acc_wr_en,
    output logic [DATA_W-1:0] acc_wr_data,
    output logic              flag_wr_en,
    output logic [DATA_W-1:0] flag_wr_data,
    output logic              unknown_op,
    output logic [LEN_W-1:0]  instr_len,
    output logic [CYC_W-1:0]  instr_cycles
);

    seq_state_e state_q;
    logic       accept;

    assign ready   = (state_q == ST_IDLE) && !done;
    assign accept  = op_valid && ready;
    assign waiting = (state_q == ST_MEM_WAIT);
    assign mem_req = waiting;

    // Purpose: state, latched operands, and single-cycle commit strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            acc_hold     <= '0;
            mem_addr     <= '0;
            done         <= 1'b0;
            acc_wr_en    <= 1'b0;
            acc_wr_data  <= '0;
            flag_wr_en   <= 1'b0;
            flag_wr_data <= '0;
            unknown_op   <= 1'b0;
            instr_len    <= '0;
            instr_cycles <= '0;
        end else begin
            done       <= 1'b0;
            acc_wr_en  <= 1'b0;
            flag_wr_en <= 1'b0;
            unknown_op <= 1'b0;
            if (accept) begin
                instr_len    <= len;
                instr_cycles <= cycles;
                case (form)
                    FORM_MEM: begin
                        state_q  <= ST_MEM_WAIT;
                        acc_hold <= acc_in;
                        mem_addr <= hl_addr;
                    end
                    FORM_NONE: begin
                        done       <= 1'b1;
                        unknown_op <= 1'b1;
                    end
                    default: begin
                        done         <= 1'b1;
                        acc_wr_en    <= 1'b1;
                        flag_wr_en   <= 1'b1;
                        acc_wr_data  <= alu_result;
                        flag_wr_data <= alu_flags;
                    end
                endcase
            end else if (waiting && mem_rvalid) begin
                state_q      <= ST_IDLE;
                done         <= 1'b1;
                acc_wr_en    <= 1'b1;
                flag_wr_en   <= 1'b1;
                acc_wr_data  <= alu_result;
                flag_wr_data <= alu_flags;
            end
        end
    end

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R3
    mem_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (done && acc_wr_en && !mem_req));

    // R9
    quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ready && (form != FORM_MEM)) |=> done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || mem_req) |-> !ready);

    // R8
    unknown_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unknown_op |-> (done && !acc_wr_en && !flag_wr_en));

endmodule

// File: rtl/xor_exec_unit.sv
// xor_exec_unit: top of the accumulator XOR execution unit.
// Decodes the opcode, selects the operand, XORs it into the accumulator and
// emits registered write strobes for the accumulator and the flag byte.
// Assumes an external register file that applies the strobes on the done edge.
module xor_exec_unit
    import xor_unit_pkg::*;
#(
    parameter int unsigned SHORT_CYCLES = 4,
    parameter int unsigned LONG_CYCLES  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [DATA_W-1:0]    opcode,
    input  logic [DATA_W-1:0]    imm_in,
    output logic                 ready,
    input  logic [DATA_W-1:0]    acc_in,
    input  logic [DATA_W-1:0]    b_in,
    input  logic [DATA_W-1:0]    c_in,
    input  logic [DATA_W-1:0]    d_in,
    input  logic [DATA_W-1:0]    e_in,
    input  logic [DATA_W-1:0]    h_in,
    input  logic [DATA_W-1:0]    l_in,
    output logic                 mem_req,
    output logic [2*DATA_W-1:0]  mem_addr,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 acc_wr_en,
    output logic [DATA_W-1:0]    acc_wr_data,
    output logic                 flag_wr_en,
    output logic [DATA_W-1:0]    flag_wr_data,
    output logic                 unknown_op,
    output logic [LEN_W-1:0]     instr_len,
    output logic [CYC_W-1:0]     instr_cycles
);

    localparam int unsigned ADDR_W = 2 * DATA_W;
    localparam int unsigned SLOTS  = 8;

    form_e                       form;
    logic [2:0]                  slot;
    logic [LEN_W-1:0]            len;
    logic [CYC_W-1:0]            cycles;
    logic [SLOTS-1:0][DATA_W-1:0] bank;
    logic [DATA_W-1:0]           mux_operand;
    logic [DATA_W-1:0]           alu_acc;
    logic [DATA_W-1:0]           alu_operand;
    logic [DATA_W-1:0]           alu_result;
    logic [DATA_W-1:0]           alu_flags;
    logic                        waiting;
    logic [DATA_W-1:0]           acc_hold;

    // Purpose: build the operand bank in slot order of the opcode group
    always_comb begin
        bank[0]        = b_in;
        bank[1]        = c_in;
        bank[2]        = d_in;
        bank[3]        = e_in;
        bank[4]        = h_in;
        bank[5]        = l_in;
        bank[SLOT_MEM] = imm_in;
        bank[SLOT_ACC] = acc_in;
    end

    // Purpose: live operands when idle, latched ones during a memory read
    always_comb begin
        alu_acc     = waiting ? acc_hold  : acc_in;
        alu_operand = waiting ? mem_rdata : mux_operand;
    end

    xor_decode #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) u_decode (
        .opcode (opcode),
        .form   (form),
        .slot   (slot),
        .len    (len),
        .cycles (cycles)
    );

    xor_operand_mux #(
        .SLOTS (SLOTS)
    ) u_mux (
        .bank    (bank),
        .slot    (slot),
        .operand (mux_operand)
    );

    xor_alu u_alu (
        .acc     (alu_acc),
        .operand (alu_operand),
        .result  (alu_result),
        .flags   (alu_flags)
    );

    xor_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .form         (form),
        .len          (len),
        .cycles       (cycles),
        .hl_addr      ({h_in, l_in}),
        .acc_in       (acc_in),
        .alu_result   (alu_result),
        .alu_flags    (alu_flags),
        .mem_rvalid   (mem_rvalid),
        .ready        (ready),
        .waiting      (waiting),
        .acc_hold     (acc_hold),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .done         (done),
        .acc_wr_en    (acc_wr_en),
        .acc_wr_data  (acc_wr_data),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_data (flag_wr_data),
        .unknown_op   (unknown_op),
        .instr_len    (instr_len),
        .instr_cycles (instr_cycles)
    );

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_en |-> (flag_wr_data == {(acc_wr_data == '0), 7'd0}));

    // R9
    write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_en |-> (flag_wr_en && done && !unknown_op));

endmodule

// File: tb/xor_exec_unit_test.sv
`timescale 1ns/1ps
module xor_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  imm_in = 8'h00;
    logic        ready;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  b_in, c_in, d_in, e_in, h_in, l_in;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        done, acc_wr_en, flag_wr_en, unknown_op;
    logic [7:0]  acc_wr_data, flag_wr_data;
    logic [1:0]  instr_len;
    logic [3:0]  instr_cycles;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xor_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .imm_in(imm_in), .ready(ready), .acc_in(acc_in),
        .b_in(b_in), .c_in(c_in), .d_in(d_in), .e_in(e_in),
        .h_in(h_in), .l_in(l_in), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .unknown_op(unknown_op), .instr_len(instr_len),
        .instr_cycles(instr_cycles)
    );

    // {opcode, acc, operand, expected acc, expected len, expected cycles}
    localparam logic [47:0] VECS [15] = '{
        {8'hA8, 8'hFF, 8'hCC, 8'h33, 8'd1, 8'd4},
        {8'hA9, 8'hFF, 8'h33, 8'hCC, 8'd1, 8'd4},
        {8'hAA, 8'h3C, 8'h3C, 8'h00, 8'd1, 8'd4},
        {8'hAB, 8'h80, 8'h01, 8'h81, 8'd1, 8'd4},
        {8'hAC, 8'h00, 8'h00, 8'h00, 8'd1, 8'd4},
        {8'hAD, 8'hF0, 8'h0F, 8'hFF, 8'd1, 8'd4},
        {8'hAF, 8'h45, 8'h00, 8'h00, 8'd1, 8'd4},
        {8'hAE, 8'hEE, 8'hBB, 8'h55, 8'd1, 8'd8},
        {8'hAE, 8'hCC, 8'hCC, 8'h00, 8'd1, 8'd8},
        {8'hEE, 8'h22, 8'hEE, 8'hCC, 8'd2, 8'd8},
        {8'hEE, 8'hCC, 8'h33, 8'hFF, 8'd2, 8'd8},
        {8'h00, 8'h12, 8'h34, 8'h00, 8'd0, 8'd0},
        {8'hA7, 8'h12, 8'h34, 8'h00, 8'd0, 8'd0},
        {8'hB0, 8'h12, 8'h34, 8'h00, 8'd0, 8'd0},
        {8'hED, 8'h12, 8'h34, 8'h00, 8'd0, 8'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic default_regs();
        b_in = 8'h11; c_in = 8'h22; d_in = 8'h44;
        e_in = 8'h88; h_in = 8'hF1; l_in = 8'hE2;
    endtask

    // Runs one opcode; for 0xAE the memory answers after two idle cycles
    task automatic run_vec(input logic [47:0] v);
        logic [7:0] op, a, opnd, expa, elen, ecyc;
        string tag;
        {op, a, opnd, expa, elen, ecyc} = v;
        @(negedge clk);
        default_regs();
        acc_in = a;
        imm_in = 8'h5A;
        case (op)
            8'hA8: b_in = opnd;
            8'hA9: c_in = opnd;
            8'hAA: d_in = opnd;
            8'hAB: e_in = opnd;
            8'hAC: h_in = opnd;
            8'hAD: l_in = opnd;
            8'hEE: imm_in = opnd;
            default: ;
        endcase
        tag = (op == 8'hAF) ? "R2" : (op == 8'hAE) ? "R3" :
              (op == 8'hEE) ? "R4" : (elen == 8'd0) ? "R8" : "R1";
        opcode = op;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        if (op == 8'hAE) begin
            check("R3 req", {31'd0, mem_req}, 32'd1);
            check("R3 addr", {16'd0, mem_addr}, {16'd0, h_in, l_in});
            acc_in = 8'h00;
            h_in = 8'h00;
            @(negedge clk);
            check("R3 hold", {16'd0, mem_addr}, 32'h0000F1E2);
            @(negedge clk);
            mem_rvalid = 1'b1;
            mem_rdata = opnd;
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rdata = 8'h00;
        end
        check({tag, " done"}, {31'd0, done}, 32'd1);
        check("R9 ready low", {31'd0, ready}, 32'd0);
        check("R6 len", {30'd0, instr_len}, {24'd0, elen});
        check("R7 cycles", {28'd0, instr_cycles}, {24'd0, ecyc});
        if (elen == 8'd0) begin
            check("R8 unknown", {31'd0, unknown_op}, 32'd1);
            check("R8 no acc write", {31'd0, acc_wr_en}, 32'd0);
            check("R8 no flag write", {31'd0, flag_wr_en}, 32'd0);
        end else begin
            check({tag, " unknown"}, {31'd0, unknown_op}, 32'd0);
            check({tag, " acc_wr_en"}, {31'd0, acc_wr_en}, 32'd1);
            check({tag, " result"}, {24'd0, acc_wr_data}, {24'd0, expa});
            check("R5 flags", {24'd0, flag_wr_data},
                  {24'd0, (expa == 8'h00), 7'd0});
        end
        @(negedge clk);
        check("R9 pulse", {31'd0, done}, 32'd0);
        check("R10 ready back", {31'd0, ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        default_regs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 ready", {31'd0, ready}, 32'd1);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 mem_req", {31'd0, mem_req}, 32'd0);
        check("R11 writes", {30'd0, acc_wr_en, flag_wr_en}, 32'd0);
        check("R11 unknown", {31'd0, unknown_op}, 32'd0);

        for (int i = 0; i < 15; i++) begin
            run_vec(VECS[i]);
        end

        // R10: opcode offered during a pending read and during done is dropped
        @(negedge clk);
        default_regs();
        acc_in = 8'h0F;
        opcode = 8'hAE;
        op_valid = 1'b1;
        @(negedge clk);
        opcode = 8'hA8;
        check("R10 busy ready", {31'd0, ready}, 32'd0);
        @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata = 8'hF0;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check("R3 mem result", {24'd0, acc_wr_data}, 32'h000000FF);
        check("R10 done once", {31'd0, done}, 32'd1);
        @(negedge clk);
        op_valid = 1'b0;
        check("R10 no extra done", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R10 ignored op", {31'd0, done}, 32'd0);
        check("R10 no write", {31'd0, acc_wr_en}, 32'd0);

        // R11: reset in the middle of a memory read
        opcode = 8'hAE;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 req cleared", {31'd0, mem_req}, 32'd0);
        check("R11 ready again", {31'd0, ready}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule